// File: doc/BRIEF.md
# Sample Frequency Reporter

This block classifies the sample rate of a recovered audio stream. It runs in the recovered master clock domain, where the clock is 256 times the sample rate, and compares that clock against a free-running reference clock with a nominal rate of 6.144 MHz. The block counts reference clock cycles over a fixed number of master clock cycles. It then turns the count into a 3-bit rate code by looking it up in a parameterised range table.

Each channel status block is split into three equal measurement windows. A block-start strobe restarts the window sequence, so every status block gets three fresh codes and the first of them follows the block boundary. The reference clock count moves into the master clock domain through a toggle handshake. The handshake carries a snapshot of a free-running counter, and the block subtracts consecutive snapshots.

The code and its valid flag are shown only while the display-select input picks frequency reporting. The valid flag needs two consecutive complete windows of reference activity before it is set, which is two thirds of a status block. It drops when the reference clock stalls for longer than a programmable number of master clock cycles.

Top module: `sample_rate_reporter`

## Requirements
- R1: A measurement window lasts FRAME_CYCLES*FRAMES_PER_THIRD master clock cycles, which is one third of a status block. Windows follow each other back to back. A block-start strobe ends the current window and starts a new one on the same clock edge.
- R2: After each window boundary, the result of the window that just ended is loaded into rate_code_o within a few cycles of handshake latency. The value loaded is the lowest index i whose inclusive range [RATE_LO entry i, RATE_HI entry i] contains the reference count. Entry i occupies bits [i*CNT_W +: CNT_W] of each table parameter.
- R3: A count that falls outside every table range yields the reserved code 2**CODE_W-1 (7 by default).
- R4: rate_vld_o rises only when the second consecutive complete-window result loads. After the first result, the code is already shown while rate_vld_o is still low.
- R5: A window cut short by a block-start strobe loads no code. rate_code_o keeps its previous value.
- R6: While sel_stat_i is high (status display), rate_code_o is 0 and rate_vld_o is 0 from the next clock edge onward, and the result streak restarts.
- R7: If the reference clock shows no activity for idle_tmo_i master clock cycles, rate_vld_o clears. After the reference clock restarts, one window only re-establishes a baseline, and two further complete windows are needed before rate_vld_o sets again.
- R8: During reset, rate_code_o is 0 and rate_vld_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Recovered master clock, 256 times the sample rate |
| rst_ni | input | 1 | Active-low asynchronous reset, both clock domains |
| blk_start_i | input | 1 | One-cycle strobe marking the start of a status block |
| sel_stat_i | input | 1 | High selects status display, low selects frequency reporting |
| ref_clk_i | input | 1 | Reference clock, nominally 6.144 MHz |
| idle_tmo_i | input | TMO_W | Reference inactivity limit in master clock cycles |
| rate_code_o | output | CODE_W | Registered sample-rate code |
| rate_vld_o | output | 1 | Code is backed by two complete windows of reference activity |

## Verification
The hardest state to reach is a truncated window, because its count is a plausible number that only the window bookkeeping rejects. The stimulus strobes block-start halfway through a window while the reference runs at a rate where half a window's count lands in a different table entry. A stale load would then show up as a wrong code. A second difficult case is a mixed window whose count is only out of range when the window has exactly the right length. The stimulus creates it by switching the reference rate at mid-window. Reference stall and restart are driven by gating the reference clock for longer than the inactivity limit, and the valid flag is then sampled both before and after the required number of fresh windows.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
package sfr_pkg;
  // bookkeeping for the one outstanding snapshot request
  typedef struct packed {
    logic use_res;  // result of this request is loaded into the code
    logic base_ok;  // snapshot lies on a window boundary
  } pend_t;

  function automatic int unsigned window_len(input int unsigned frame_cyc,
                                             input int unsigned frames);
    return frame_cyc * frames;
  endfunction
endpackage

// File: rtl/sfr_sync.sv
`timescale 1ns/1ps
module sfr_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sfr_ref_snap.sv
`timescale 1ns/1ps
module sfr_ref_snap #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ACT_BIT = 3
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             req_tgl_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             ack_tgl_o,
  output logic             act_o
);
  logic [CNT_W-1:0] cnt_q, snap_q;
  logic             ack_q, req_s;

  sfr_sync #(.WIDTH(1), .STAGES(2)) u_req_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_i),
    .q_o   (req_s)
  );

  // free-running count; snapshot frozen until the next request toggle
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (req_s != ack_q) begin
        snap_q <= cnt_q;
        ack_q  <= req_s;
      end
    end
  end

  assign snap_o    = snap_q;
  assign ack_tgl_o = ack_q;
  assign act_o     = cnt_q[ACT_BIT];
endmodule

// File: rtl/sfr_window.sv
`timescale 1ns/1ps
module sfr_window #(
  parameter int unsigned WIN_CYC = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk_i,
  output logic tick_o,
  output logic part_o
);
  localparam int unsigned WIN_W = $clog2(WIN_CYC);
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYC - 1);

  logic [WIN_W-1:0] win_q;
  logic             at_end;

  assign at_end = (win_q == LAST);
  assign tick_o = blk_i | at_end;
  assign part_o = blk_i & ~at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= '0;
    else if (tick_o) win_q <= '0;
    else             win_q <= win_q + 1'b1;
  end
endmodule

// File: rtl/sfr_code_map.sv
`timescale 1ns/1ps
module sfr_code_map #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = 3,
  parameter logic [(2**CODE_W-1)*CNT_W-1:0] LO = '0,
  parameter logic [(2**CODE_W-1)*CNT_W-1:0] HI = '0
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned NUM = 2**CODE_W - 1;

  logic [NUM-1:0] hit;

  for (genvar i = 0; i < NUM; i++) begin : g_ent
    assign hit[i] = (cnt_i >= LO[i*CNT_W +: CNT_W]) && (cnt_i <= HI[i*CNT_W +: CNT_W]);
  end

  // lowest matching entry wins; no match gives the reserved code
  always_comb begin
    code_o = CODE_W'(NUM);
    for (int i = NUM - 1; i >= 0; i--) begin
      if (hit[i]) code_o = CODE_W'(i);
    end
  end
endmodule

// File: rtl/sample_rate_reporter.sv
`timescale 1ns/1ps
module sample_rate_reporter
  import sfr_pkg::*;
#(
  parameter int unsigned FRAME_CYCLES     = 256,
  parameter int unsigned FRAMES_PER_THIRD = 64,
  parameter int unsigned CNT_W            = 16,
  parameter int unsigned CODE_W           = 3,
  parameter int unsigned TMO_W            = 16,
  parameter int unsigned ACT_BIT          = 3,
  parameter logic [(2**CODE_W-1)*CNT_W-1:0] RATE_LO =
    {16'd15892, 16'd11919, 16'd8649, 16'd7946, 16'd5960, 16'd4324, 16'd3973},
  parameter logic [(2**CODE_W-1)*CNT_W-1:0] RATE_HI =
    {16'd16876, 16'd12657, 16'd9183, 16'd8438, 16'd6328, 16'd4592, 16'd4219}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_start_i,
  input  logic              sel_stat_i,
  input  logic              ref_clk_i,
  input  logic [TMO_W-1:0]  idle_tmo_i,
  output logic [CODE_W-1:0] rate_code_o,
  output logic              rate_vld_o
);
  localparam int unsigned WIN_CYC  = window_len(FRAME_CYCLES, FRAMES_PER_THIRD);
  localparam int unsigned WIN_W    = $clog2(WIN_CYC);
  localparam logic [CODE_W-1:0] OOR_CODE = CODE_W'(2**CODE_W - 1);

  logic             tick, part;
  logic [CNT_W-1:0] snap, prev_q, delta;
  logic             ack_ref, act_ref, ack_s, act_s;
  logic             req_q, ack_seen_q, act_d_q;
  logic             busy, done, act_edge, dead, fmode;
  logic [TMO_W-1:0] idle_q;
  pend_t            pend_q;
  logic             have_base_q;
  logic [1:0]       streak_q;
  logic [CODE_W-1:0] code_q, map_code;
  logic             vld_q;

  sfr_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .blk_i (blk_start_i),
    .tick_o(tick),
    .part_o(part)
  );

  sfr_ref_snap #(.CNT_W(CNT_W), .ACT_BIT(ACT_BIT)) u_snap (
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .req_tgl_i(req_q),
    .snap_o   (snap),
    .ack_tgl_o(ack_ref),
    .act_o    (act_ref)
  );

  sfr_sync #(.WIDTH(1), .STAGES(2)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_ref),
    .q_o   (ack_s)
  );

  sfr_sync #(.WIDTH(1), .STAGES(2)) u_act_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (act_ref),
    .q_o   (act_s)
  );

  // snapshot is stable once the ack toggle has crossed over
  assign delta = snap - prev_q;

  sfr_code_map #(.CNT_W(CNT_W), .CODE_W(CODE_W), .LO(RATE_LO), .HI(RATE_HI)) u_map (
    .cnt_i (delta),
    .code_o(map_code)
  );

  assign fmode    = ~sel_stat_i;
  assign busy     = (req_q != ack_s);
  assign done     = (ack_s != ack_seen_q);
  assign act_edge = (act_s != act_d_q);
  assign dead     = (idle_q >= idle_tmo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q       <= 1'b0;
      ack_seen_q  <= 1'b0;
      act_d_q     <= 1'b0;
      idle_q      <= '0;
      pend_q      <= '0;
      prev_q      <= '0;
      have_base_q <= 1'b0;
      streak_q    <= '0;
      code_q      <= '0;
      vld_q       <= 1'b0;
    end else begin
      ack_seen_q <= ack_s;
      act_d_q    <= act_s;

      if (act_edge)           idle_q <= '0;
      else if (idle_q != '1)  idle_q <= idle_q + 1'b1;

      if (tick) begin
        if (!busy) begin
          req_q          <= ~req_q;
          pend_q.use_res <= have_base_q & ~part & fmode & ~dead;
          pend_q.base_ok <= ~dead;
        end else begin
          // previous snapshot never returned: its timing is lost
          pend_q   <= '0;
          streak_q <= '0;
        end
      end

      if (done) begin
        prev_q      <= snap;
        have_base_q <= pend_q.base_ok;
        if (pend_q.use_res) begin
          code_q <= map_code;
          if (streak_q != 2'd0) vld_q <= 1'b1;
          if (streak_q != 2'd2) streak_q <= streak_q + 1'b1;
        end
      end

      if (dead) begin
        pend_q      <= '0;
        have_base_q <= 1'b0;
        streak_q    <= '0;
        vld_q       <= 1'b0;
      end

      if (!fmode) begin
        pend_q.use_res <= 1'b0;
        streak_q       <= '0;
        code_q         <= '0;
        vld_q          <= 1'b0;
      end
    end
  end

  assign rate_code_o = code_q;
  assign rate_vld_o  = vld_q;

  // ---------------------------------------------------------------- checks
  logic [WIN_W:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !blk_start_i) |-> (gap_q == (WIN_W+1)'(WIN_CYC - 1)));

  assert_single_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q != $past(req_q)) |-> ($past(req_q) == $past(ack_s)));

  assert_code_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && pend_q.use_res && fmode && !dead) |=>
      ((code_q == OOR_CODE) ||
       (($past(delta) >= RATE_LO[int'(code_q)*CNT_W +: CNT_W]) &&
        ($past(delta) <= RATE_HI[int'(code_q)*CNT_W +: CNT_W]))));

  assert_vld_after_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rate_vld_o) |-> $past(done && pend_q.use_res && (streak_q != 2'd0)));

  assert_partial_dropped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && part) |=> !pend_q.use_res);

  assert_sel_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_stat_i |=> ((rate_code_o == '0) && !rate_vld_o));

  assert_idle_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead |=> !rate_vld_o);
endmodule

// File: tb/test_sample_rate_reporter.sv
`timescale 1ns/1ps
module test_sample_rate_reporter;
  localparam int CNT_W  = 16;
  localparam int CODE_W = 3;
  // window = 16*4 = 64 cycles of 20 ns -> count = 1280 / ref_period_ns
  localparam logic [7*CNT_W-1:0] T_LO =
    {16'd1000, 16'd1000, 16'd1000, 16'd76, 16'd30, 16'd60, 16'd120};
  localparam logic [7*CNT_W-1:0] T_HI =
    {16'd1001, 16'd1001, 16'd1001, 16'd84, 16'd34, 16'd68, 16'd136};

  // vectors: select, reference half period (ns), expected code, expected valid
  localparam int VN = 8;
  localparam int V_SEL [VN] = '{0, 0, 0, 0, 0, 1, 0, 0};
  localparam int V_HALF[VN] = '{10, 5, 20, 8, 12, 10, 10, 5};
  localparam int V_CODE[VN] = '{1, 0, 2, 3, 7, 0, 1, 0};
  localparam int V_VLD [VN] = '{1, 1, 1, 1, 1, 0, 1, 1};

  logic        clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic        blk_start = 1'b0, sel = 1'b0;
  logic [15:0] idle_tmo = 16'd40;
  logic [CODE_W-1:0] code;
  logic        vld;

  int  ref_half = 10;
  bit  ref_on = 1'b1;
  bit  auto_blk = 1'b0;
  int  ph = 0;
  int  n_cmp = 0, n_bad = 0;
  bit  ended = 1'b0;

  sample_rate_reporter #(
    .FRAME_CYCLES(16), .FRAMES_PER_THIRD(4), .CNT_W(CNT_W), .CODE_W(CODE_W),
    .TMO_W(16), .ACT_BIT(3), .RATE_LO(T_LO), .RATE_HI(T_HI)
  ) i_sample_rate_reporter (
    .clk_i(clk), .rst_ni(rst_n), .blk_start_i(blk_start), .sel_stat_i(sel),
    .ref_clk_i(ref_clk), .idle_tmo_i(idle_tmo), .rate_code_o(code), .rate_vld_o(vld)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      #(ref_half);
      if (ref_on) ref_clk = ~ref_clk;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      blk_start = auto_blk && (ph % 192 == 0);
      ph++;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_run();
  end

  initial begin
    // R8: reset state
    cyc(5);
    chk("R8 code in reset", int'(code), 0);
    chk("R8 valid in reset", int'(vld), 0);
    rst_n = 1'b1;

    // R4: first window is baseline, second shows code, third sets valid
    cyc(96);
    chk("R4 baseline code", int'(code), 0);
    chk("R4 baseline valid", int'(vld), 0);
    cyc(64);
    chk("R4 first result code", int'(code), 1);
    chk("R4 first result valid low", int'(vld), 0);
    cyc(64);
    chk("R4 second result valid", int'(vld), 1);

    // align windows to block strobes, then walk the vector table (R2 R3 R6)
    auto_blk = 1'b1;
    ph = 0;
    cyc(32);
    for (int v = 0; v < VN; v++) begin
      sel      = V_SEL[v][0];
      ref_half = V_HALF[v];
      cyc(256);
      chk($sformatf("R2/R3/R6 vector %0d code", v), int'(code), V_CODE[v]);
      chk($sformatf("R2/R6 vector %0d valid", v), int'(vld), V_VLD[v]);
    end

    // R1: mid-window rate switch; 96 counts only if the window is 64 cycles
    ref_half = 10;
    cyc(128);
    chk("R2 settle code", int'(code), 1);
    ref_half = 5;
    cyc(64);
    chk("R1 mixed window code", int'(code), 7);
    cyc(64);
    chk("R1 following full window code", int'(code), 0);

    // R5: truncated window (would read code 1) is dropped
    auto_blk  = 1'b0;
    blk_start = 1'b1;
    cyc(1);
    cyc(32);
    chk("R5 code after partial window", int'(code), 0);
    chk("R5 valid after partial window", int'(vld), 1);

    // R7: reference stall clears valid, restart needs fresh windows
    ref_on = 1'b0;
    cyc(80);
    chk("R7 valid after stall", int'(vld), 0);
    ref_on = 1'b1;
    cyc(48);
    chk("R7 valid soon after restart", int'(vld), 0);
    cyc(224);
    chk("R7 valid after fresh windows", int'(vld), 1);
    chk("R7 code after fresh windows", int'(code), 0);

    finish_run();
  end
endmodule